// File: doc/BRIEF.md
# Paged Frame Buffer Access Arbiter

This block sits between a CPU bus and a bitmap memory that holds sixteen complete monochrome display images, 128 dots wide and 32 lines tall at one bit per dot, or 512 bytes per image. The CPU and a display refresh engine share one single-port memory. Ownership is fixed by a phase input rather than by request and grant: while the phase is low the CPU owns the memory, and while it is high the refresh engine owns it. A CPU access made in its own phase always completes in that cycle, so the CPU never waits.

The CPU sees a small address space. Its top bit selects either a 1 KB RAM window or a register space. The RAM window has two 512-byte halves. Each half is steered to any one of the sixteen images by its own CPU page register. A third register picks the image that the refresh engine reads. The CPU can therefore draw into one or two images while a different image is on the display. The refresh engine supplies only a byte offset within the page, and the block adds the display page. An 8 KB behavioural memory model is part of the block.

Top module: `fb_page_arbiter`

## Requirements
- R1: While rst_n is sampled low, all three page registers return to page 0 and cpu_rdata and rfr_rdata return to zero.
- R2: cpu_addr[10]=0 selects the RAM window. cpu_addr[10]=1 selects the registers, indexed by cpu_addr[1:0]: 0 is the low CPU page, 1 is the high CPU page, 2 is the display page, and 3 reads as zero and ignores writes. cpu_addr[9:2] are ignored in register space.
- R3: In the RAM window, cpu_addr[9]=0 maps to physical address {low page, cpu_addr[8:0]} and cpu_addr[9]=1 maps to {high page, cpu_addr[8:0]}.
- R4: A register write with phase low stores cpu_wdata[3:0]. The new value is in force for the next cycle. A register read returns the 4-bit page zero-extended to 8 bits.
- R5: While phase is low, mem_addr carries the mapped CPU address, mem_wdata carries cpu_wdata, and mem_we equals cpu_wr for RAM-window accesses (0 for register accesses).
- R6: While phase is high, mem_addr is {display page, rfr_addr} and mem_we is 0. CPU strobes then have no effect on memory, registers or cpu_rdata.
- R7: A CPU read strobe with phase low loads cpu_rdata at that clock edge with the addressed byte or register. If a write to the same byte happens at the same edge, the read returns the old contents. cpu_rdata holds its value at every other edge.
- R8: At every clock edge with phase high, rfr_rdata loads the byte at {display page, rfr_addr}. It holds its value while phase is low.
- R9: The display page is independent of both CPU pages. A CPU write into the displayed page is seen by the very next refresh read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| phase | input | 1 | Memory owner: 0 CPU, 1 refresh engine |
| cpu_addr | input | 11 | CPU address (bit 10 register space, bit 9 half, bits 8:0 offset) |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rd | input | 1 | CPU read strobe |
| cpu_wr | input | 1 | CPU write strobe |
| rfr_addr | input | 9 | Refresh byte offset within the display page |
| mem_addr | output | 13 | Physical memory address {page, offset} |
| mem_we | output | 1 | Memory write enable |
| mem_wdata | output | 8 | Memory write data |
| cpu_rdata | output | 8 | CPU read data, registered |
| rfr_rdata | output | 8 | Refresh read data, registered |

## Verification
Two functions can meet on adjacent or identical edges. One is a CPU write into the page being displayed. The other is the refresh read of that same byte. The bench provokes this in two ways. In the first, a CPU-phase write to a byte of the displayed page is followed at once by a refresh-phase read of the same offset. In the second, the display page register is rewritten in the cycle just before a refresh read. The refresh data must reflect the new byte or the new page. The bench also issues a read and a write to the same byte at one edge, and the result must be the old byte. A behavioural model checks every cycle's outputs.

// File: rtl/fb_pkg.sv
// Package: shared register index type and the per-image size constants
// for the paged frame buffer arbiter.
package fb_pkg;
    typedef enum logic [1:0] {
        REG_LOW_PG  = 2'd0,
        REG_HIGH_PG = 2'd1,
        REG_DISP_PG = 2'd2,
        REG_SPARE   = 2'd3
    } reg_idx_e;

    localparam int IMG_COLS = 128;
    localparam int IMG_ROWS = 32;
endpackage

// File: rtl/fb_page_regs.sv
// Module: fb_page_regs
// Holds the low CPU page, high CPU page and display page registers.
// Assumes wr_en is already qualified by CPU phase and register decode.
// Provides the read-back value zero-extended to the data width.
module fb_page_regs
    import fb_pkg::*;
#(
    parameter int PG_W = 4,
    parameter int DW   = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  reg_idx_e        idx,
    input  logic [PG_W-1:0] wdata,
    output logic [PG_W-1:0] low_pg,
    output logic [PG_W-1:0] high_pg,
    output logic [PG_W-1:0] disp_pg,
    output logic [DW-1:0]   rd_val
);
    localparam int NREG = 3;

    logic [PG_W-1:0] pg_q [NREG];

    generate
        for (genvar i = 0; i < NREG; i++) begin : g_pg
            // Store one page register; reset to page 0.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    pg_q[i] <= '0;
                else if (wr_en && (idx == reg_idx_e'(i)))
                    pg_q[i] <= wdata;
            end
        end
    endgenerate

    assign low_pg  = pg_q[0];
    assign high_pg = pg_q[1];
    assign disp_pg = pg_q[2];

    // Select the read-back value; the spare index reads zero.
    always_comb begin
        rd_val = '0;
        case (idx)
            REG_LOW_PG:  rd_val[PG_W-1:0] = pg_q[0];
            REG_HIGH_PG: rd_val[PG_W-1:0] = pg_q[1];
            REG_DISP_PG: rd_val[PG_W-1:0] = pg_q[2];
            default:     rd_val = '0;
        endcase
    end

    // R4: a low-page write lands on the next cycle.
    a_r4_low_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && idx == REG_LOW_PG) |=> (low_pg == $past(wdata)));

    // R6: without a write strobe the display page holds.
    a_r6_disp_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(disp_pg));
endmodule

// File: rtl/fb_addr_map.sv
// Module: fb_addr_map
// Decodes the CPU address into RAM window or register space and builds
// the physical address from the owning side's page and offset.
// Assumes phase is synchronous to clk; purely combinational.
module fb_addr_map
    import fb_pkg::*;
#(
    parameter int PG_W  = 4,
    parameter int OFF_W = 9
) (
    input  logic                  phase,
    input  logic [OFF_W+1:0]      cpu_addr,
    input  logic                  cpu_rd,
    input  logic                  cpu_wr,
    input  logic [OFF_W-1:0]      rfr_addr,
    input  logic [PG_W-1:0]       low_pg,
    input  logic [PG_W-1:0]       high_pg,
    input  logic [PG_W-1:0]       disp_pg,
    output logic [PG_W+OFF_W-1:0] mem_addr,
    output logic                  mem_we,
    output logic                  cpu_rd_go,
    output logic                  ram_hit,
    output logic                  reg_wr,
    output reg_idx_e              reg_idx
);
    localparam int SPACE_BIT = OFF_W + 1;
    localparam int HALF_BIT  = OFF_W;

    logic            cpu_slot;
    logic [PG_W-1:0] cpu_pg;

    // First-level decode: owner phase, RAM window versus register space.
    always_comb begin
        cpu_slot  = !phase;
        ram_hit   = !cpu_addr[SPACE_BIT];
        cpu_rd_go = cpu_slot && cpu_rd;
        mem_we    = cpu_slot && cpu_wr && ram_hit;
        reg_wr    = cpu_slot && cpu_wr && !ram_hit;
        reg_idx   = reg_idx_e'(cpu_addr[1:0]);
    end

    // Window half picks which CPU page register applies.
    always_comb begin
        cpu_pg = cpu_addr[HALF_BIT] ? high_pg : low_pg;
    end

    // Physical address from whichever side owns the memory this cycle.
    always_comb begin
        if (phase)
            mem_addr = {disp_pg, rfr_addr};
        else
            mem_addr = {cpu_pg, cpu_addr[OFF_W-1:0]};
    end
endmodule

// File: rtl/fb_bitmap_ram.sv
// Module: fb_bitmap_ram
// Behavioural single-port bitmap memory: synchronous write and
// combinational read, so a same-edge read sees the old contents.
// Assumes no reset of contents.
module fb_bitmap_ram #(
    parameter int AW = 13,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    // Write the addressed byte when enabled.
    always_ff @(posedge clk) begin
        if (we)
            mem[addr] <= wdata;
    end

    assign rdata = mem[addr];
endmodule

// File: rtl/fb_page_arbiter.sv
// Module: fb_page_arbiter
// Top level: shares one bitmap memory between a CPU and a refresh engine.
// The phase input gives fixed ownership (0 CPU, 1 refresh), so CPU
// accesses never stall. Holds the page registers and registers read data
// for both sides. Assumes phase and all inputs are synchronous to clk.
module fb_page_arbiter
    import fb_pkg::*;
#(
    parameter int PAGES      = 16,
    parameter int PAGE_BYTES = (IMG_COLS * IMG_ROWS) / 8,
    parameter int DW         = 8,
    localparam int PG_W      = $clog2(PAGES),
    localparam int OFF_W     = $clog2(PAGE_BYTES),
    localparam int MA_W      = PG_W + OFF_W,
    localparam int CA_W      = OFF_W + 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            phase,
    input  logic [CA_W-1:0] cpu_addr,
    input  logic [DW-1:0]   cpu_wdata,
    input  logic            cpu_rd,
    input  logic            cpu_wr,
    input  logic [OFF_W-1:0] rfr_addr,
    output logic [MA_W-1:0] mem_addr,
    output logic            mem_we,
    output logic [DW-1:0]   mem_wdata,
    output logic [DW-1:0]   cpu_rdata,
    output logic [DW-1:0]   rfr_rdata
);
    logic [PG_W-1:0] low_pg, high_pg, disp_pg;
    logic [DW-1:0]   reg_rd_val, ram_q;
    logic            cpu_rd_go, ram_hit, reg_wr;
    reg_idx_e        reg_idx;

    fb_page_regs #(.PG_W(PG_W), .DW(DW)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (reg_wr),
        .idx     (reg_idx),
        .wdata   (cpu_wdata[PG_W-1:0]),
        .low_pg  (low_pg),
        .high_pg (high_pg),
        .disp_pg (disp_pg),
        .rd_val  (reg_rd_val)
    );

    fb_addr_map #(.PG_W(PG_W), .OFF_W(OFF_W)) u_map (
        .phase     (phase),
        .cpu_addr  (cpu_addr),
        .cpu_rd    (cpu_rd),
        .cpu_wr    (cpu_wr),
        .rfr_addr  (rfr_addr),
        .low_pg    (low_pg),
        .high_pg   (high_pg),
        .disp_pg   (disp_pg),
        .mem_addr  (mem_addr),
        .mem_we    (mem_we),
        .cpu_rd_go (cpu_rd_go),
        .ram_hit   (ram_hit),
        .reg_wr    (reg_wr),
        .reg_idx   (reg_idx)
    );

    assign mem_wdata = cpu_wdata;

    fb_bitmap_ram #(.AW(MA_W), .DW(DW)) u_ram (
        .clk   (clk),
        .we    (mem_we),
        .addr  (mem_addr),
        .wdata (mem_wdata),
        .rdata (ram_q)
    );

    // Capture CPU read data on a CPU-phase read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cpu_rdata <= '0;
        else if (cpu_rd_go)
            cpu_rdata <= ram_hit ? ram_q : reg_rd_val;
    end

    // Capture refresh data on every refresh-phase edge.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rfr_rdata <= '0;
        else if (phase)
            rfr_rdata <= ram_q;
    end

    // R6: the refresh phase never writes memory.
    a_r6_no_write_in_refresh: assert property (@(posedge clk) disable iff (!rst_n)
        phase |-> !mem_we);

    // R6: the refresh phase addresses the display page.
    a_r6_refresh_page: assert property (@(posedge clk) disable iff (!rst_n)
        phase |-> (mem_addr[MA_W-1:OFF_W] == disp_pg));

    // R7: CPU read data holds unless a CPU-phase read happened.
    a_r7_cpu_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(cpu_rd && !phase) |=> $stable(cpu_rdata));

    // R8: refresh data holds through CPU phases.
    a_r8_rfr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !phase |=> $stable(rfr_rdata));
endmodule

// File: tb/fb_page_arbiter_test.sv
// Bench: behavioural reference model compared against the block every cycle.
module fb_page_arbiter_test;
    logic        clk = 1'b0;
    logic        rst_n, phase, cpu_rd, cpu_wr;
    logic [10:0] cpu_addr;
    logic [7:0]  cpu_wdata;
    logic [8:0]  rfr_addr;
    logic [12:0] mem_addr;
    logic        mem_we;
    logic [7:0]  mem_wdata, cpu_rdata, rfr_rdata;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;
    bit done     = 1'b0;

    // Reference state
    logic [7:0] mm [8192];
    int lo_m = 0, hi_m = 0, dp_m = 0;
    logic [7:0] e_cpu = 8'h00, e_rfr = 8'h00;

    always #10 clk = ~clk;

    fb_page_arbiter uut (
        .clk(clk), .rst_n(rst_n), .phase(phase), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
        .rfr_addr(rfr_addr), .mem_addr(mem_addr), .mem_we(mem_we),
        .mem_wdata(mem_wdata), .cpu_rdata(cpu_rdata), .rfr_rdata(rfr_rdata)
    );

    task automatic chk(input string tag, input string what, input int got, input int exp);
        n_checks++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, got, exp);
        end
    endtask

    function automatic logic [7:0] pat(input int p, input int o);
        return 8'((p * 37) + (o * 5) + (o >> 3));
    endfunction

    // One cycle: drive, check combinational outputs, clock, update model, check registers.
    task automatic cycle(input string tag, input bit rn, input bit ph, input int a,
                         input int wd, input bit rd, input bit wr, input int ra);
        int pg, ma;
        bit ram;
        rst_n = rn; phase = ph; cpu_addr = 11'(a); cpu_wdata = 8'(wd);
        cpu_rd = rd; cpu_wr = wr; rfr_addr = 9'(ra);
        #1;
        ram = !cpu_addr[10];
        pg  = cpu_addr[9] ? hi_m : lo_m;
        ma  = ph ? (dp_m * 512 + ra) : (pg * 512 + int'(cpu_addr[8:0]));
        if (rn) begin
            chk(tag, "mem_addr (R3 R5 R6)", int'(mem_addr), ma);
            chk(tag, "mem_we (R5 R6)", int'(mem_we), int'(!ph && wr && ram));
            if (!ph) chk(tag, "mem_wdata (R5)", int'(mem_wdata), wd & 255);
        end
        @(posedge clk);
        if (!rn) begin
            lo_m = 0; hi_m = 0; dp_m = 0; e_cpu = 8'h00; e_rfr = 8'h00;
        end else if (!ph) begin
            if (rd) begin
                if (ram) e_cpu = mm[ma];
                else case (cpu_addr[1:0])
                    2'd0: e_cpu = 8'(lo_m);
                    2'd1: e_cpu = 8'(hi_m);
                    2'd2: e_cpu = 8'(dp_m);
                    default: e_cpu = 8'h00;
                endcase
            end
            if (wr) begin
                if (ram) mm[ma] = 8'(wd);
                else case (cpu_addr[1:0])
                    2'd0: lo_m = wd & 15;
                    2'd1: hi_m = wd & 15;
                    2'd2: dp_m = wd & 15;
                    default: ;
                endcase
            end
        end else begin
            e_rfr = mm[dp_m * 512 + ra];
        end
        @(negedge clk);
        chk(tag, "cpu_rdata (R7)", int'(cpu_rdata), int'(e_cpu));
        chk(tag, "rfr_rdata (R8)", int'(rfr_rdata), int'(e_rfr));
    endtask

    task automatic cpu_w(input string tag, input int a, input int d);
        cycle(tag, 1, 0, a, d, 0, 1, 0);
    endtask

    task automatic cpu_r(input string tag, input int a, input int exp);
        cycle(tag, 1, 0, a, 0, 1, 0, 0);
        chk(tag, "read value", int'(cpu_rdata), exp);
    endtask

    task automatic rfr(input string tag, input int ra, input int exp);
        cycle(tag, 1, 1, 0, 0, 0, 0, ra);
        chk(tag, "refresh value", int'(rfr_rdata), exp);
    endtask

    // Watchdog
    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 100000 && !done) begin
                n_checks++; n_fail++;
                $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
                $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
                $finish;
            end
        end
    end

    initial begin
        for (int i = 0; i < 8192; i++) mm[i] = 8'h00;
        rst_n = 0; phase = 0; cpu_addr = '0; cpu_wdata = '0;
        cpu_rd = 0; cpu_wr = 0; rfr_addr = '0;
        @(negedge clk);
        // R1: reset clears captures and registers
        for (int i = 0; i < 3; i++) cycle("R1", 0, i[0], 0, 0, 1, 0, i);
        chk("R1", "cpu_rdata after reset", int'(cpu_rdata), 0);
        chk("R1", "rfr_rdata after reset", int'(rfr_rdata), 0);
        cpu_w("R1", 11'h400, 9); cpu_r("R1", 11'h400, 9); // non-zero first
        cycle("R1", 0, 0, 0, 0, 0, 0, 0);
        cpu_r("R1", 11'h400, 0); cpu_r("R1", 11'h401, 0); cpu_r("R1", 11'h402, 0);

        // R2 R3: fill every page through the low half
        for (int p = 0; p < 16; p++) begin
            cpu_w("R2", 11'h400, p);
            for (int o = 0; o < 512; o++) cpu_w("R3", o, pat(p, o));
        end
        cpu_r("R4", 11'h400, 15);

        // R3: high half through a different page
        cpu_w("R4", 11'h401, 5);
        cpu_r("R4", 11'h401, 5);
        cpu_r("R3", 11'h200 + 17, pat(5, 17));
        cpu_r("R3", 11'h3FF, pat(5, 511));
        cpu_r("R3", 11'h000, pat(15, 0));
        cpu_w("R3", 11'h200 + 40, 8'hA5);
        cpu_w("R3", 11'h400, 5);
        cpu_r("R3", 40, 8'hA5);

        // R2: register space mirrors and spare index
        cpu_r("R2", 11'h7FD, 5);
        cpu_w("R2", 11'h403, 8'hFF);
        cpu_r("R2", 11'h403, 0);
        cpu_r("R2", 11'h400, 5); cpu_r("R2", 11'h401, 5); cpu_r("R2", 11'h402, 0);

        // R4: write to register then readback zero-extended
        cpu_w("R4", 11'h400, 8'hF3);
        cpu_r("R4", 11'h400, 3);

        // R8 R9: refresh from display page 7, interleaved CPU reads
        cpu_w("R9", 11'h402, 7);
        for (int k = 0; k < 40; k++) begin
            rfr("R8", k * 13, pat(7, k * 13));
            cpu_r("R7", k * 11, pat(3, k * 11));
        end

        // R6: CPU strobes during refresh phase have no effect
        cycle("R6", 1, 1, 11'h402, 2, 1, 1, 5);
        cycle("R6", 1, 1, 11'h005, 8'h77, 1, 1, 5);
        cpu_r("R6", 11'h402, 7);
        cpu_w("R6", 11'h400, 7);
        cpu_r("R6", 5, pat(7, 5));

        // R7: read and write of one byte at one edge returns old data
        cycle("R7", 1, 0, 9, 8'h3C, 1, 1, 0);
        chk("R7", "same-edge read", int'(cpu_rdata), int'(pat(7, 9)));
        cpu_r("R7", 9, 8'h3C);

        // R9: write into displayed page, refresh the next cycle
        cpu_w("R9", 100, 8'hC3);
        rfr("R9", 100, 8'hC3);
        cpu_w("R9", 11'h402, 2);
        rfr("R9", 100, pat(2, 100));
        rfr("R9", 9, pat(2, 9));
        cpu_r("R9", 11'h400, 7);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule